// File: doc/BRIEF.md
# Host-Mapped GPIO Register Bank

This block gives a host processor register-level control over 24 general-purpose pins, arranged as three ports of eight pins, and reports the state of two on-board LED drivers in the top bits of the data word. The host reaches it over a simple request/acknowledge register bus. The host sets which pins are inputs, sets the levels that output pins drive, and chooses one of eight drive modes for each pin. The block turns those settings into per-pin pad controls: output enable, output value, pull-up select and pull-down select. It samples the input pins through a two-flop synchronizer.

The data register reads back a merged word. Each input pin shows its synchronized level and each output pin shows the value the host wrote. In the direction register a set bit means input, and all pins come out of reset as inputs. Drive modes are held in one register per port. In the first cycle after reset is released, these registers are loaded from a parallel default input.

A small bus state machine sequences the block:
- **ST_INIT** is entered on reset. It loads the default drive modes and ignores the bus. It always moves to ST_IDLE.
- **ST_IDLE** waits for a request. It moves to ST_ACK when a request is accepted, and on that same edge a write takes effect and the read word is captured.
- **ST_ACK** raises the acknowledge for one cycle and presents the read data. It always returns to ST_IDLE, and any request still held during ST_ACK is not acted on.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads 0x00FFFFFF (with the LED bits at 30 and 31 as driven), the data register reads 0, and no pin has its output enable set.
- R2: In the direction and data words, port p pin n sits at bit 8p+n. The register addresses are: direction at 0, data at 1, and the drive modes of port p at address 2+p. In a mode word, pin n's 3-bit code sits at bits [3n+2:3n] and bits 24-31 read 0.
- R3: A direction bit of 1 makes the pin an input, and the pin's output enable stays 0. A direction bit of 0 makes the pin an output.
- R4: The data register value drives `pin_out`: a written 1 drives high and a written 0 drives low. A data read returns the synchronized pin level for input pins and the written value for output pins.
- R5: Bits 24-29 of the direction and data words always read 0, and writes to them are discarded.
- R6: Bits 30 and 31 of the direction and data words read `led_drv[0]` and `led_drv[1]`. Writes to those bits have no effect.
- R7: A change on `pin_in` is not visible in a read whose request is accepted on the first or second rising edge after the change. It is visible in a read accepted later.
- R8: The drive-mode codes are: 0 strong, 1 open-drain high, 2 open-drain low, 3 pull-up, 4 pull-down, 5 pull-up/down, 6 high-impedance digital, 7 high-impedance analog. For an output pin driving value d, the output enable is 1 for mode 0, d for modes 1 and 4, !d for modes 2 and 3, and 0 otherwise. The pull-up select is set for modes 3 and 5, and the pull-down select is set for modes 4 and 5.
- R9: While a pin is in mode 7, its sampled input reads 0.
- R10: In the first cycle after reset release (ST_INIT), every mode register loads from `mode_default`, and a bus request in that cycle is ignored.
- R11: A request accepted in ST_IDLE gives `bus_ack` high for exactly one cycle on the following cycle (ST_ACK), with `bus_rdata` holding the register value from before any write on that same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| pin_in | input | 24 | Pin input levels (asynchronous) |
| pin_oe | output | 24 | Per-pin output enable |
| pin_out | output | 24 | Per-pin output value |
| pin_pu | output | 24 | Per-pin pull-up select |
| pin_pd | output | 24 | Per-pin pull-down select |
| led_drv | input | 2 | LED drive levels mirrored into bits 30-31 |
| mode_default | input | 72 | Power-up drive modes, 3 bits per pin |

## Verification
The merged readback is driven with a mixed direction pattern. In that pattern one port drives 0x55 while another port's inputs see 0x55, so a swapped merge, a per-port offset error or an inverted direction bit each gives a visibly different word. All-ones writes to the direction register show whether the unused gap and the LED bits are kept out of the stored state, and toggling `led_drv` separates live mirroring from stored bits. Each of the eight drive-mode codes is applied to an output pin with both data values, which tells apart every output-enable and pull entry in the table. An input step read on the second and on a later edge pins down the synchronizer depth.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        DM_STRONG  = 3'd0,
        DM_OD_HI   = 3'd1,
        DM_OD_LO   = 3'd2,
        DM_PULL_UP = 3'd3,
        DM_PULL_DN = 3'd4,
        DM_PULL_UD = 3'd5,
        DM_HIZ_DIG = 3'd6,
        DM_HIZ_ANA = 3'd7
    } drv_mode_e;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_ACK  = 2'd2
    } bus_state_e;
endpackage

// File: rtl/gpb_sync.sv
`timescale 1ns/1ps
module gpb_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpb_pad_ctrl.sv
`timescale 1ns/1ps
module gpb_pad_ctrl
    import gpb_pkg::*;
#(
    parameter int NPIN = 24
) (
    input  logic [NPIN-1:0]        dir_in,
    input  logic [NPIN-1:0]        dout,
    input  logic [NPIN*MODE_W-1:0] mode,
    output logic [NPIN-1:0]        oe,
    output logic [NPIN-1:0]        pu,
    output logic [NPIN-1:0]        pd,
    output logic [NPIN-1:0]        analog
);
    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            drv_mode_e m;
            logic      drv;
            assign m = drv_mode_e'(mode[i*MODE_W +: MODE_W]);

            always_comb begin
                drv       = 1'b0;
                pu[i]     = 1'b0;
                pd[i]     = 1'b0;
                analog[i] = 1'b0;
                unique case (m)
                    DM_STRONG:  drv = 1'b1;
                    DM_OD_HI:   drv = dout[i];
                    DM_OD_LO:   drv = ~dout[i];
                    DM_PULL_UP: begin drv = ~dout[i]; pu[i] = 1'b1; end
                    DM_PULL_DN: begin drv = dout[i];  pd[i] = 1'b1; end
                    DM_PULL_UD: begin pu[i] = 1'b1; pd[i] = 1'b1; end
                    DM_HIZ_DIG: drv = 1'b0;
                    DM_HIZ_ANA: analog[i] = 1'b1;
                endcase
                oe[i] = drv & ~dir_in[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int PORTS         = 3,
    parameter int PINS_PER_PORT = 8,
    parameter int LEDS          = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    bus_req,
    input  logic                                    bus_we,
    input  logic [$clog2(2+PORTS)-1:0]              bus_addr,
    input  logic [31:0]                             bus_wdata,
    output logic [31:0]                             bus_rdata,
    output logic                                    bus_ack,
    input  logic [PORTS*PINS_PER_PORT-1:0]          pin_in,
    output logic [PORTS*PINS_PER_PORT-1:0]          pin_oe,
    output logic [PORTS*PINS_PER_PORT-1:0]          pin_out,
    output logic [PORTS*PINS_PER_PORT-1:0]          pin_pu,
    output logic [PORTS*PINS_PER_PORT-1:0]          pin_pd,
    input  logic [LEDS-1:0]                         led_drv,
    input  logic [PORTS*PINS_PER_PORT*MODE_W-1:0]   mode_default
);
    localparam int WORD_W     = 32;
    localparam int NPIN       = PORTS * PINS_PER_PORT;
    localparam int MODE_REG_W = PINS_PER_PORT * MODE_W;
    localparam int LED_LSB    = WORD_W - LEDS;
    localparam int ADDR_W     = $clog2(2 + PORTS);
    localparam logic [ADDR_W-1:0] ADDR_DIR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(1);
    localparam int ADDR_MODE0 = 2;

    bus_state_e                 state_q, state_nx;
    logic [NPIN-1:0]            dir_q, data_q, sync_q, analog_mask, in_live;
    logic [NPIN*MODE_W-1:0]     mode_q;
    logic [WORD_W-1:0]          rd_word;
    logic                       accept;
    logic                       unused_wdata;

    assign unused_wdata = ^bus_wdata[WORD_W-1:NPIN];
    assign accept = (state_q == ST_IDLE) && bus_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_INIT: state_nx = ST_IDLE;
            ST_IDLE: if (bus_req) state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_INIT;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            data_q <= '0;
            mode_q <= '0;
        end else if (state_q == ST_INIT) begin
            mode_q <= mode_default;
        end else if (accept && bus_we) begin
            if (bus_addr == ADDR_DIR)  dir_q  <= bus_wdata[NPIN-1:0];
            if (bus_addr == ADDR_DATA) data_q <= bus_wdata[NPIN-1:0];
            for (int p = 0; p < PORTS; p++) begin
                if (bus_addr == ADDR_W'(ADDR_MODE0 + p))
                    mode_q[p*MODE_REG_W +: MODE_REG_W] <= bus_wdata[MODE_REG_W-1:0];
            end
        end
    end

    gpb_sync #(.WIDTH(NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
    );

    gpb_pad_ctrl #(.NPIN(NPIN)) u_pad (
        .dir_in(dir_q), .dout(data_q), .mode(mode_q),
        .oe(pin_oe), .pu(pin_pu), .pd(pin_pd), .analog(analog_mask)
    );

    assign pin_out = data_q;
    assign in_live = sync_q & ~analog_mask;

    always_comb begin
        rd_word = '0;
        if (bus_addr == ADDR_DIR) begin
            rd_word[NPIN-1:0]          = dir_q;
            rd_word[WORD_W-1:LED_LSB]  = led_drv;
        end else if (bus_addr == ADDR_DATA) begin
            rd_word[NPIN-1:0]          = (dir_q & in_live) | (~dir_q & data_q);
            rd_word[WORD_W-1:LED_LSB]  = led_drv;
        end else begin
            for (int p = 0; p < PORTS; p++) begin
                if (bus_addr == ADDR_W'(ADDR_MODE0 + p))
                    rd_word[MODE_REG_W-1:0] = mode_q[p*MODE_REG_W +: MODE_REG_W];
            end
        end
    end

    // output process: acknowledge and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= accept;
            if (accept) bus_rdata <= rd_word;
        end
    end

    // R11: acknowledge lasts a single cycle
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R5: unused gap reads zero
    p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[29:24] == 6'd0));

    // R3: an input pin is never driven
    p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R3: a direction write lands in the following cycle
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_we && bus_addr == ADDR_DIR) |=> (dir_q == $past(bus_wdata[NPIN-1:0])));

    // R10: modes load from the default input, and no access is taken in ST_INIT
    p_mode_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> (mode_q == $past(mode_default)));
    p_init_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> !bus_ack);

    // R8: analog mode neither drives nor pulls
    p_analog_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_mask & (pin_oe | pin_pu | pin_pd)) == '0);
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
    localparam int NPIN = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ack;
    logic [23:0] pin_in, pin_oe, pin_out, pin_pu, pin_pd;
    logic [1:0]  led_drv;
    logic [71:0] mode_default;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .pin_pu(pin_pu), .pin_pd(pin_pd), .led_drv(led_drv),
        .mode_default(mode_default)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R11 write ack", {31'd0, bus_ack}, 32'd1);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R11 read ack", {31'd0, bus_ack}, 32'd1);
        d = bus_rdata;
        @(negedge clk);
        chk("R11 ack one cycle", {31'd0, bus_ack}, 32'd0);
    endtask

    function automatic logic [31:0] mode_word(input int m0, input int rest);
        logic [31:0] w = '0;
        for (int n = 0; n < 8; n++) w[3*n +: 3] = (n == 0) ? 3'(m0) : 3'(rest);
        return w;
    endfunction

    task automatic t_reset_and_init();
        logic [31:0] r;
        logic [31:0] exp_mode;
        // R10: a write request held across reset release must be ignored in ST_INIT
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 no ack in init", {31'd0, bus_ack}, 32'd0);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        chk("R1 no output enable", {8'd0, pin_oe}, 32'd0);
        bus_read(3'd0, r);
        chk("R1 R10 dir reset value", r, 32'h00FF_FFFF);
        bus_read(3'd1, r);
        chk("R1 data reset value", r, 32'h0);
        for (int p = 0; p < 3; p++) begin
            exp_mode = '0;
            for (int n = 0; n < 8; n++) exp_mode[3*n +: 3] = 3'((8*p + n) % 8);
            bus_read(3'(2 + p), r);
            chk("R10 R2 mode default load", r, exp_mode);
        end
    endtask

    task automatic t_merge();
        logic [31:0] r;
        for (int p = 0; p < 3; p++) bus_write(3'(2 + p), mode_word(0, 0));
        bus_write(3'd0, 32'h00FF_00FF);
        bus_write(3'd1, 32'h0000_5500);
        chk("R4 R2 pin_out port1", {8'd0, pin_out}, 32'h0000_5500);
        chk("R3 oe port1 only", {8'd0, pin_oe}, 32'h0000_FF00);
        @(negedge clk) pin_in = 24'h0000_55;
        repeat (3) @(negedge clk);
        bus_read(3'd1, r);
        chk("R4 merged readback", r, 32'h0000_5555);
        pin_in = 24'hAA_FFFF;
        repeat (3) @(negedge clk);
        bus_read(3'd1, r);
        chk("R4 R2 merged other pattern", r, 32'h00AA_55FF);
    endtask

    task automatic t_gap_and_leds();
        logic [31:0] r;
        bus_write(3'd0, 32'hFFFF_FFFF);
        led_drv = 2'b00;
        bus_read(3'd0, r);
        chk("R5 R6 gap ignores writes", r, 32'h00FF_FFFF);
        led_drv = 2'b10;
        bus_read(3'd0, r);
        chk("R6 led bit31 in dir", r, 32'h80FF_FFFF);
        led_drv = 2'b01;
        bus_write(3'd0, 32'h0000_0000);
        bus_write(3'd1, 32'hFF00_0000);
        bus_read(3'd1, r);
        chk("R6 R5 led bit30 data, top writes dropped", r, 32'h4000_0000);
        led_drv = 2'b00;
    endtask

    task automatic t_sync();
        logic [31:0] r;
        bus_write(3'd0, 32'h00FF_FFFF);
        @(negedge clk) pin_in = 24'h00_0000;
        repeat (3) @(negedge clk);
        pin_in = 24'h00_0001;
        bus_read(3'd1, r);
        chk("R7 not visible on second edge", r, 32'h0);
        bus_read(3'd1, r);
        chk("R7 visible later", r, 32'h1);
    endtask

    task automatic t_modes();
        logic [31:0] r;
        logic e_oe, e_pu, e_pd;
        bus_write(3'd0, 32'h00FF_FFFE);
        for (int d = 0; d < 2; d++) begin
            bus_write(3'd1, 32'(d));
            for (int m = 0; m < 8; m++) begin
                bus_write(3'd2, mode_word(m, 6));
                case (m)
                    0: e_oe = 1'b1;
                    1, 4: e_oe = d[0];
                    2, 3: e_oe = ~d[0];
                    default: e_oe = 1'b0;
                endcase
                e_pu = (m == 3) || (m == 5);
                e_pd = (m == 4) || (m == 5);
                chk($sformatf("R8 oe mode %0d d %0d", m, d), {31'd0, pin_oe[0]}, {31'd0, e_oe});
                chk($sformatf("R8 pu mode %0d", m), {31'd0, pin_pu[0]}, {31'd0, e_pu});
                chk($sformatf("R8 pd mode %0d", m), {31'd0, pin_pd[0]}, {31'd0, e_pd});
            end
        end
        // R9: analog mode masks the sampled input of an input pin
        bus_write(3'd0, 32'h00FF_FFFF);
        pin_in = 24'h00_0001;
        bus_write(3'd2, mode_word(7, 6));
        repeat (3) @(negedge clk);
        bus_read(3'd1, r);
        chk("R9 analog reads zero", r, 32'h0);
        bus_write(3'd2, mode_word(6, 6));
        bus_read(3'd1, r);
        chk("R9 digital hiz reads level", r, 32'h1);
        bus_read(3'd2, r);
        chk("R2 mode word top byte zero", r & 32'hFF00_0000, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0;
        pin_in = '0; led_drv = 2'b00;
        for (int i = 0; i < NPIN; i++) mode_default[3*i +: 3] = 3'(i % 8);
        repeat (3) @(negedge clk);
        t_reset_and_init();
        t_merge();
        t_gap_and_leds();
        t_sync();
        t_modes();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule